// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned 16-bit number by another over a fixed run of clock cycles. It uses one subtractor and three registers. The partial remainder, the quotient and the divisor each have their own register. On each step the remainder and quotient pair shifts left by one bit. A trial difference against the divisor is then formed as a combinational value. On the same clock edge, the shifted remainder takes either that difference or its own shifted value. The remainder register never holds a failed difference, so no restore cycle is needed to add the divisor back.

To use the block, a client pulses `start` while `busy` is low, with the operands on `dividend` and `divisor`. After a fixed number of cycles, `done` pulses once. From then on, `quotient` and `remainder` hold the result until the next accepted start. Dividing by zero does not trap. It gives the value that the normal iteration produces.

Top module: `seq_divider`

## Requirements
- R1: While reset is held, and until the first accepted start, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: When `start` is high at a clock edge and `busy` is low, the operands are captured on that edge, and `busy` is 1 after that edge.
- R3: `done` is 1 for exactly one cycle. It rises after the 16th clock edge that follows the edge which accepted the operands, and `busy` falls on that same edge. `busy` and `done` are never both 1.
- R4: For a nonzero divisor, `quotient` is the integer quotient and `remainder` is the modulo, once `done` is 1.
- R5: For a divisor of zero, `quotient` is 16'hFFFF and `remainder` equals the dividend.
- R6: A `start` seen while `busy` is 1 is ignored. The running division finishes with its own timing and its own result.
- R7: While `busy` is 0 and no start is accepted, `quotient` and `remainder` do not change.
- R8: On each step, the remainder is shifted left and the top quotient bit enters its bottom bit. The quotient bit is 1 when the trial difference carries or when the bit shifted out of the remainder was 1. While a run with a nonzero divisor is in progress, `remainder` shows the partial remainder, which always stays below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a division; accepted only while idle |
| dividend | input | 16 | Numerator, sampled on the accepting edge |
| divisor | input | 16 | Denominator, sampled on the accepting edge |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| quotient | output | 16 | Quotient register (shows partial bits while busy) |
| remainder | output | 16 | Remainder register (shows the partial remainder while busy) |

## Verification
The assertions assume that `start`, `dividend` and `divisor` are stable around the rising edge. They also assume that the operands matter only on the edge where a start is accepted. The bench drives every input on the falling edge. It holds the operands steady while `start` is high. The bench keeps `start` low during reset and for several cycles after reset is released, so no start lands in the reset-synchroniser window. Its stimulus covers a zero divisor, all-ones operands, mid-run starts and a `start` held high for many runs.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/div_trial.sv
// One step of trial subtraction, combinational only.
module div_trial #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_in,
  input  logic         quo_msb,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] shifted,
  output logic [W-1:0] diff,
  output logic         take
);
  logic [W:0] sum;
  logic       carry;

  always_comb begin
    shifted = {rem_in[W-2:0], quo_msb};
    sum     = {1'b0, shifted} + {1'b0, ~dvs} + (W+1)'(1);
    carry   = sum[W];
    diff    = sum[W-1:0];
    take    = carry | rem_in[W-1];
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  import div_pkg::*;

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RUN: begin
        step   = 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == LAST) |=> (done && !busy));
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] rem_q,
  output logic [W-1:0] quo_q
);
  logic [W-1:0] rem_d, quo_d, dvs_q, dvs_d;
  logic [W-1:0] shifted, diff;
  logic         take;
  logic         rem_en, dvs_en;

  div_trial #(.W(W)) u_trial (
    .rem_in  (rem_q),
    .quo_msb (quo_q[W-1]),
    .dvs     (dvs_q),
    .shifted (shifted),
    .diff    (diff),
    .take    (take)
  );

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    rem_en = load | step;
    dvs_en = load;
    if (load) begin
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
    end else if (step) begin
      rem_d = take ? diff : shifted;
      quo_d = {quo_q[W-2:0], take};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else begin
      if (rem_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
      end
      if (dvs_en) dvs_q <= dvs_d;
    end
  end

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(rem_q) && $stable(quo_q)));
  // R8
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dvs_q != '0) |=> (rem_q < dvs_q));
  // R5
  zero_div_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dvs_q == '0) |=> quo_q[0]);
  // R8
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (quo_q[W-1:1] == $past(quo_q[W-2:0])));
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic rst_int_n;
  logic load, step;

  div_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  div_ctrl #(.W(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  div_datapath #(.W(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .step     (step),
    .dividend (dividend),
    .divisor  (divisor),
    .rem_q    (remainder),
    .quo_q    (quotient)
  );
endmodule

// File: tb/seq_divider_test.sv
`timescale 1ns/1ps
module seq_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done;
  logic [15:0] quotient, remainder;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  // reference model state
  bit m_busy, m_done;
  int m_a, m_q, m_b, m_cnt, m_dvd, m_dvs;
  bit fresh;

  always #4 clk = ~clk;

  seq_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_a = 0; m_q = 0; m_b = 0; m_cnt = 0; fresh = 0;
    end else begin
      m_done = 0;
      fresh = 0;
      if (m_busy) begin
        int a2, q2;
        a2 = m_a * 2 + ((m_q >> 15) & 1);
        q2 = (m_q << 1) & 16'hFFFF;
        if (a2 >= m_b) begin
          a2 = a2 - m_b;
          q2 = q2 | 1;
        end
        m_a = a2 & 16'hFFFF;
        m_q = q2;
        if (m_cnt == 15) begin m_busy = 0; m_done = 1; end
        m_cnt++;
      end else if (start) begin
        m_a = 0; m_q = dividend; m_b = divisor; m_dvd = dividend; m_dvs = divisor;
        m_busy = 1; m_cnt = 0; fresh = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      longint act, exp;
      act = {busy, done, quotient, remainder};
      exp = {m_busy, m_done, m_q[15:0], m_a[15:0]};
      if (fresh)       chk(act == exp && busy, "R2", act, exp);
      else if (m_done) chk(act == exp, "R3", act, exp);
      else if (m_busy) chk(act == exp, "R8", act, exp);
      else             chk(act == exp, "R7", act, exp);
      if (m_done && done) begin
        if (m_dvs != 0) begin
          chk(quotient == m_dvd / m_dvs, "R4", quotient, m_dvd / m_dvs);
          chk(remainder == m_dvd % m_dvs, "R4", remainder, m_dvd % m_dvs);
        end else begin
          chk(quotient == 16'hFFFF, "R5", quotient, 16'hFFFF);
          chk(remainder == m_dvd, "R5", remainder, m_dvd);
        end
      end
    end
  end

  task automatic run(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    start = 1; dividend = a; divisor = b;
    @(negedge clk);
    start = 0;
    repeat (17) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, quotient, remainder} == 0, "R1", {busy, done, quotient, remainder}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk({busy, done, quotient, remainder} == 0, "R1", {busy, done, quotient, remainder}, 0);
    run(16'd100, 16'd7);
    run(16'd0, 16'd1);
    run(16'hFFFF, 16'd1);
    run(16'hFFFF, 16'hFFFF);
    run(16'd1, 16'hFFFF);
    run(16'h8000, 16'd3);
    run(16'hFFFF, 16'd2);
    run(16'd12345, 16'd0);   // R5
    run(16'd0, 16'd0);       // R5
    run(16'h8001, 16'h8000);
    // R6: new start in the middle of a run must be ignored
    @(negedge clk); start = 1; dividend = 16'd5000; divisor = 16'd9;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    start = 1; dividend = 16'd77; divisor = 16'd2;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(quotient != 16'd38 || busy, "R6", quotient, 0);
    repeat (12) @(negedge clk);
    // start held high: each run accepted as soon as idle
    start = 1; dividend = 16'd4321; divisor = 16'd13;
    repeat (60) @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = (i % 3 == 0) ? 16'($urandom_range(1, 255)) : 16'($urandom);
      run(ra, rb);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule